// File: doc/BRIEF.md
# Global Pad Three-State Controller

This block produces one device-wide safe-state command and turns it into per-class pad controls. When the command is active, every user pad stops driving, its input is pulled high and set to the TTL threshold. The test data output and the done pin also stop driving, and the done input is pulled up. The three dedicated control inputs (configuration read, reset and program) stay usable with their pull-ups on. When the command is inactive, every pad class passes its normal programmed settings through unchanged.

The command source depends on a small state machine with two states. In `PH_CONFIG` (entered at reset and whenever a new configuration starts) the command comes only from the dedicated test pad, active-low, with no inversion. In `PH_USER` the source is chosen by a two-bit select: off, the test pad, or an internal routing signal. A polarity bit can invert the sense of the chosen source. There are two transitions. *config-done* moves `PH_CONFIG` to `PH_USER` when the configuration flag is sampled low. *reconfigure* moves `PH_USER` back to `PH_CONFIG` when the flag is sampled high. The command is taken from a flip-flop, so a source change never glitches it.

Top module: `gts_ctrl`

## Requirements
- R1: While reset is asserted, the machine is in `PH_CONFIG`, `ts_active` is 0 and all pad controls equal their request inputs.
- R2: In `PH_CONFIG`, the command is the inverse of `ts_pad_n`; `src_sel`, `ts_invert` and `ts_route` have no effect.
- R3: In `PH_USER` with `src_sel` 00 or 11, the command is never active, whatever the pad, routing or invert inputs are.
- R4: In `PH_USER` with `src_sel` 01 and `ts_invert` 0, the command is the inverse of `ts_pad_n`.
- R5: In `PH_USER` with `src_sel` 10 and `ts_invert` 0, the command is the inverse of `ts_route`.
- R6: In `PH_USER`, `ts_invert` 1 makes the selected pad or routing source active-high.
- R7: `ts_active` is registered: after each clock edge it reflects the phase and the inputs sampled at that edge. At the edge where `cfg_active` is first sampled low, the test pad still decides, and the chosen source takes over from the next edge.
- R8: While the command is active: `io_oe` is all 0, `io_pu` is all 1, `io_pd` is all 0, and `io_ttl` is all 1 (1 selects the TTL threshold).
- R9: While the command is active: `tdo_oe` is 0, `done_oe` is 0 and `done_pu` is 1.
- R10: `ded_pu` is `ded_pu_req` ORed with the command, so the dedicated inputs' pull-ups are on whenever the command is active and no enable of theirs is ever removed.
- R11: While the command is inactive, every pad control output equals its request input.
- R12: At the edge where `cfg_active` is sampled high in `PH_USER`, the machine returns to `PH_CONFIG`, and from the next edge only the test pad controls the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | 1 | High while configuration is in progress |
| ts_pad_n | input | 1 | Dedicated test pad, active-low |
| ts_route | input | 1 | Internal routing source |
| src_sel | input | 2 | Post-configuration source: 00 off, 01 pad, 10 routing, 11 off |
| ts_invert | input | 1 | Post-configuration sense inversion |
| usr_oe | input | NUM_IO | Requested user output enables |
| usr_pu | input | NUM_IO | Requested user pull-ups |
| usr_pd | input | NUM_IO | Requested user pull-downs |
| usr_ttl | input | NUM_IO | Requested user threshold select (1 = TTL) |
| tdo_oe_req | input | 1 | Requested test data output enable |
| done_oe_req | input | 1 | Requested done output enable |
| done_pu_req | input | 1 | Requested done pull-up |
| ded_pu_req | input | NUM_DED | Requested pull-ups of the dedicated control inputs |
| ts_active | output | 1 | Registered global three-state command |
| io_oe | output | NUM_IO | User output enables |
| io_pu | output | NUM_IO | User pull-ups |
| io_pd | output | NUM_IO | User pull-downs |
| io_ttl | output | NUM_IO | User threshold select |
| tdo_oe | output | 1 | Test data output enable |
| done_oe | output | 1 | Done output enable |
| done_pu | output | 1 | Done pull-up |
| ded_pu | output | NUM_DED | Dedicated control input pull-ups |

## Verification
The hardest situation to reach is the handoff edge. At that edge `cfg_active` is already sampled low but the test pad still decides, while the routing source selected for later would give the opposite answer. The stimulus sets up that disagreement before releasing the flag: the pad is inactive, the select is routing and the routing signal is low. The next cycle must then show the command inactive, and only the cycle after that active. The reverse handoff is set up the same way, with the routing source active when `cfg_active` rises again.

// File: rtl/gts_pkg.sv
`timescale 1ns/1ps
package gts_pkg;

    typedef enum logic {
        PH_CONFIG = 1'b0,
        PH_USER   = 1'b1
    } phase_e;

    localparam logic [1:0] SRC_OFF   = 2'b00;
    localparam logic [1:0] SRC_PAD   = 2'b01;
    localparam logic [1:0] SRC_ROUTE = 2'b10;
    localparam logic [1:0] SRC_RSVD  = 2'b11;

    // Default sense is active-low; inversion makes the raw level active-high.
    function automatic logic sense(input logic raw, input logic inv);
        return inv ? raw : ~raw;
    endfunction

endpackage

// File: rtl/gts_phase_fsm.sv
`timescale 1ns/1ps
module gts_phase_fsm
    import gts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_active,
    input  logic       ts_pad_n,
    input  logic       ts_route,
    input  logic [1:0] src_sel,
    input  logic       ts_invert,
    output phase_e     phase_q,
    output logic       cmd_next
);

    phase_e phase_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_CONFIG;
        else        phase_q <= phase_d;
    end

    // transitions: config-done and reconfigure
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_CONFIG: if (!cfg_active) phase_d = PH_USER;
            PH_USER:   if (cfg_active)  phase_d = PH_CONFIG;
        endcase
    end

    // command source per state
    always_comb begin
        cmd_next = 1'b0;
        unique case (phase_q)
            PH_CONFIG: cmd_next = ~ts_pad_n;
            PH_USER: begin
                unique case (src_sel)
                    SRC_PAD:   cmd_next = sense(ts_pad_n, ts_invert);
                    SRC_ROUTE: cmd_next = sense(ts_route, ts_invert);
                    SRC_OFF:   cmd_next = 1'b0;
                    SRC_RSVD:  cmd_next = 1'b0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/gts_cmd_reg.sv
`timescale 1ns/1ps
module gts_cmd_reg #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/gts_io_cell.sv
`timescale 1ns/1ps
module gts_io_cell (
    input  logic safe,
    input  logic oe_req,
    input  logic pu_req,
    input  logic pd_req,
    input  logic ttl_req,
    output logic oe,
    output logic pu,
    output logic pd,
    output logic ttl
);

    always_comb begin
        if (safe) begin
            oe  = 1'b0;
            pu  = 1'b1;
            pd  = 1'b0;
            ttl = 1'b1;
        end else begin
            oe  = oe_req;
            pu  = pu_req;
            pd  = pd_req;
            ttl = ttl_req;
        end
    end

endmodule

// File: rtl/gts_fixed_pads.sv
`timescale 1ns/1ps
module gts_fixed_pads #(
    parameter int NUM_DED = 3
) (
    input  logic               safe,
    input  logic               tdo_oe_req,
    input  logic               done_oe_req,
    input  logic               done_pu_req,
    input  logic [NUM_DED-1:0] ded_pu_req,
    output logic               tdo_oe,
    output logic               done_oe,
    output logic               done_pu,
    output logic [NUM_DED-1:0] ded_pu
);

    assign tdo_oe  = tdo_oe_req  & ~safe;
    assign done_oe = done_oe_req & ~safe;
    assign done_pu = done_pu_req |  safe;

    for (genvar g = 0; g < NUM_DED; g++) begin : g_ded
        assign ded_pu[g] = ded_pu_req[g] | safe;
    end

endmodule

// File: rtl/gts_ctrl.sv
`timescale 1ns/1ps
module gts_ctrl
    import gts_pkg::*;
#(
    parameter int NUM_IO  = 8,
    parameter int NUM_DED = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_active,
    input  logic               ts_pad_n,
    input  logic               ts_route,
    input  logic [1:0]         src_sel,
    input  logic               ts_invert,
    input  logic [NUM_IO-1:0]  usr_oe,
    input  logic [NUM_IO-1:0]  usr_pu,
    input  logic [NUM_IO-1:0]  usr_pd,
    input  logic [NUM_IO-1:0]  usr_ttl,
    input  logic               tdo_oe_req,
    input  logic               done_oe_req,
    input  logic               done_pu_req,
    input  logic [NUM_DED-1:0] ded_pu_req,
    output logic               ts_active,
    output logic [NUM_IO-1:0]  io_oe,
    output logic [NUM_IO-1:0]  io_pu,
    output logic [NUM_IO-1:0]  io_pd,
    output logic [NUM_IO-1:0]  io_ttl,
    output logic               tdo_oe,
    output logic               done_oe,
    output logic               done_pu,
    output logic [NUM_DED-1:0] ded_pu
);

    phase_e phase_q;
    logic   cmd_next;

    gts_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_active (cfg_active),
        .ts_pad_n   (ts_pad_n),
        .ts_route   (ts_route),
        .src_sel    (src_sel),
        .ts_invert  (ts_invert),
        .phase_q    (phase_q),
        .cmd_next   (cmd_next)
    );

    gts_cmd_reg #(.RESET_VAL(1'b0)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmd_next),
        .q     (ts_active)
    );

    for (genvar i = 0; i < NUM_IO; i++) begin : g_io
        gts_io_cell u_cell (
            .safe    (ts_active),
            .oe_req  (usr_oe[i]),
            .pu_req  (usr_pu[i]),
            .pd_req  (usr_pd[i]),
            .ttl_req (usr_ttl[i]),
            .oe      (io_oe[i]),
            .pu      (io_pu[i]),
            .pd      (io_pd[i]),
            .ttl     (io_ttl[i])
        );
    end

    gts_fixed_pads #(.NUM_DED(NUM_DED)) u_fixed (
        .safe        (ts_active),
        .tdo_oe_req  (tdo_oe_req),
        .done_oe_req (done_oe_req),
        .done_pu_req (done_pu_req),
        .ded_pu_req  (ded_pu_req),
        .tdo_oe      (tdo_oe),
        .done_oe     (done_oe),
        .done_pu     (done_pu),
        .ded_pu      (ded_pu)
    );

endmodule

// File: rtl/gts_ctrl_chk.sv
`timescale 1ns/1ps
module gts_ctrl_chk
    import gts_pkg::*;
#(
    parameter int NUM_IO  = 8,
    parameter int NUM_DED = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_active,
    input logic               ts_pad_n,
    input logic [1:0]         src_sel,
    input phase_e             phase_q,
    input logic               ts_active,
    input logic [NUM_IO-1:0]  usr_oe,
    input logic [NUM_IO-1:0]  usr_pu,
    input logic [NUM_IO-1:0]  usr_pd,
    input logic [NUM_IO-1:0]  usr_ttl,
    input logic               tdo_oe_req,
    input logic               done_oe_req,
    input logic               done_pu_req,
    input logic [NUM_DED-1:0] ded_pu_req,
    input logic [NUM_IO-1:0]  io_oe,
    input logic [NUM_IO-1:0]  io_pu,
    input logic [NUM_IO-1:0]  io_pd,
    input logic [NUM_IO-1:0]  io_ttl,
    input logic               tdo_oe,
    input logic               done_oe,
    input logic               done_pu,
    input logic [NUM_DED-1:0] ded_pu
);

    // R2
    cfg_pad_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_q) == PH_CONFIG) |-> (ts_active == !$past(ts_pad_n)));

    // R3
    src_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_q) == PH_USER &&
         ($past(src_sel) == 2'b00 || $past(src_sel) == 2'b11)) |-> !ts_active);

    // R8
    user_pads_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_active |-> (io_oe == '0 && io_pu == '1 && io_pd == '0 && io_ttl == '1));

    // R9
    fixed_pads_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_active |-> (!tdo_oe && !done_oe && done_pu));

    // R10
    ded_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_active |-> (ded_pu == '1));

    // R11
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_active |-> (io_oe == usr_oe && io_pu == usr_pu && io_pd == usr_pd &&
                        io_ttl == usr_ttl && tdo_oe == tdo_oe_req &&
                        done_oe == done_oe_req && done_pu == done_pu_req &&
                        ded_pu == ded_pu_req));

    // R12
    reconfig_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_q) == PH_USER && $past(cfg_active)) |-> phase_q == PH_CONFIG);

endmodule

bind gts_ctrl gts_ctrl_chk #(.NUM_IO(NUM_IO), .NUM_DED(NUM_DED)) u_chk (.*);

// File: tb/gts_ctrl_test.sv
`timescale 1ns/1ps
module gts_ctrl_test;

    localparam int N = 8;
    localparam int D = 3;
    localparam int W = 1 + 4*N + 3 + D;

    typedef struct {
        logic [W-1:0] v;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_active = 1'b1;
    logic         ts_pad_n = 1'b1;
    logic         ts_route = 1'b1;
    logic [1:0]   src_sel = 2'b00;
    logic         ts_invert = 1'b0;
    logic [N-1:0] usr_oe = '0, usr_pu = '0, usr_pd = '0, usr_ttl = '0;
    logic         tdo_oe_req = 1'b0, done_oe_req = 1'b0, done_pu_req = 1'b0;
    logic [D-1:0] ded_pu_req = '0;
    logic         ts_active;
    logic [N-1:0] io_oe, io_pu, io_pd, io_ttl;
    logic         tdo_oe, done_oe, done_pu;
    logic [D-1:0] ded_pu;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    bit    phase_user = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;

    gts_ctrl #(.NUM_IO(N), .NUM_DED(D)) uut (.*);

    function automatic logic [W-1:0] expect_vec(input logic act);
        if (act)
            return {1'b1, {N{1'b0}}, {N{1'b1}}, {N{1'b0}}, {N{1'b1}}, 1'b0, 1'b0, 1'b1, {D{1'b1}}};
        return {1'b0, usr_oe, usr_pu, usr_pd, usr_ttl, tdo_oe_req, done_oe_req, done_pu_req, ded_pu_req};
    endfunction

    function automatic logic [W-1:0] seen_vec();
        return {ts_active, io_oe, io_pu, io_pd, io_ttl, tdo_oe, done_oe, done_pu, ded_pu};
    endfunction

    task automatic check(input logic [W-1:0] exp, input string tag);
        total++;
        if (seen_vec() !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, seen_vec(), exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive(input logic cfg, input logic pad_n, input logic route,
                         input logic [1:0] sel, input logic inv,
                         input logic [N-1:0] oe, input logic [N-1:0] pu,
                         input logic [N-1:0] pd, input logic [N-1:0] ttl,
                         input logic [3+D-1:0] misc, input string tag);
        item_t it;
        logic  act;
        @(posedge clk);
        #3;
        cfg_active = cfg; ts_pad_n = pad_n; ts_route = route;
        src_sel = sel; ts_invert = inv;
        usr_oe = oe; usr_pu = pu; usr_pd = pd; usr_ttl = ttl;
        {tdo_oe_req, done_oe_req, done_pu_req, ded_pu_req} = misc;
        if (!phase_user) act = !pad_n;
        else begin
            case (sel)
                2'b01:   act = inv ? pad_n : !pad_n;
                2'b10:   act = inv ? route : !route;
                default: act = 1'b0;
            endcase
        end
        it.v = expect_vec(act);
        it.tag = tag;
        q.push_back(it);
        phase_user = !cfg;
    endtask

    // monitor: compares one cycle after each driven item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.v, it.tag);
            end
        end
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R7: actual=hung expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds command low even with the pad asserted
        ts_pad_n = 1'b0;
        usr_oe = 8'hA5; usr_pu = 8'h3C; usr_pd = 8'h0F; usr_ttl = 8'h81;
        {tdo_oe_req, done_oe_req, done_pu_req, ded_pu_req} = 6'b110_010;
        repeat (3) @(posedge clk);
        #2;
        check(expect_vec(1'b0), "R1 reset pass-through");
        @(posedge clk);
        #3;
        rst_n = 1'b1;
        ts_pad_n = 1'b1;

        // R2: configuration phase, pad only
        drive(1, 1, 0, 2'b10, 1, 8'hFF, 8'h00, 8'hFF, 8'h00, 6'b111_000, "R2 cfg pad idle, route ignored");
        drive(1, 0, 1, 2'b00, 0, 8'hFF, 8'h00, 8'hFF, 8'h00, 6'b110_001, "R2 R8 R9 R10 cfg pad active");
        drive(1, 0, 1, 2'b10, 1, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 6'b100_100, "R2 cfg pad active, invert ignored");
        drive(1, 1, 0, 2'b10, 0, 8'h12, 8'h34, 8'h56, 8'h78, 6'b011_010, "R2 cfg route low ignored");
        // R7: handoff edge still uses the pad, routing takes over next
        drive(0, 1, 0, 2'b10, 0, 8'h12, 8'h34, 8'h56, 8'h78, 6'b011_010, "R7 handoff edge uses pad");
        drive(0, 1, 0, 2'b10, 0, 8'h12, 8'h34, 8'h56, 8'h78, 6'b011_010, "R7 R5 routing low active");
        drive(0, 0, 1, 2'b10, 0, 8'hC3, 8'h3C, 8'h99, 8'h66, 6'b101_101, "R5 routing high idle, pad ignored");
        // R6: inverted routing
        drive(0, 1, 1, 2'b10, 1, 8'hC3, 8'h3C, 8'h99, 8'h66, 6'b101_101, "R6 inverted routing high active");
        drive(0, 1, 0, 2'b10, 1, 8'hC3, 8'h3C, 8'h99, 8'h66, 6'b101_101, "R6 inverted routing low idle");
        // R4: pad source
        drive(0, 0, 1, 2'b01, 0, 8'hF0, 8'h0F, 8'hAA, 8'h55, 6'b010_011, "R4 pad low active");
        drive(0, 1, 0, 2'b01, 0, 8'hF0, 8'h0F, 8'hAA, 8'h55, 6'b010_011, "R4 pad high idle, route ignored");
        drive(0, 1, 0, 2'b01, 1, 8'hF0, 8'h0F, 8'hAA, 8'h55, 6'b010_011, "R6 inverted pad high active");
        // R3: disabled codes
        drive(0, 0, 0, 2'b00, 0, 8'h0F, 8'hF0, 8'h33, 8'hCC, 6'b001_110, "R3 sel 00 pad and route low");
        drive(0, 1, 1, 2'b00, 1, 8'h0F, 8'hF0, 8'h33, 8'hCC, 6'b001_110, "R3 sel 00 inverted");
        drive(0, 0, 0, 2'b11, 0, 8'h0F, 8'hF0, 8'h33, 8'hCC, 6'b001_110, "R3 sel 11 low inputs");
        drive(0, 1, 1, 2'b11, 1, 8'h0F, 8'hF0, 8'h33, 8'hCC, 6'b001_110, "R3 sel 11 inverted");
        // R11: pass-through patterns
        drive(0, 1, 1, 2'b10, 0, 8'h00, 8'hFF, 8'h00, 8'hFF, 6'b000_000, "R11 pattern a");
        drive(0, 1, 1, 2'b10, 0, 8'hFF, 8'h00, 8'hFF, 8'h00, 6'b111_111, "R11 pattern b");
        // R12: reconfigure edge still uses routing, then pad only
        drive(1, 1, 0, 2'b10, 0, 8'h69, 8'h96, 8'h69, 8'h96, 6'b110_000, "R12 reconfigure edge uses routing");
        drive(1, 1, 0, 2'b10, 0, 8'h69, 8'h96, 8'h69, 8'h96, 6'b110_000, "R12 back in config pad idle");
        drive(1, 0, 0, 2'b00, 0, 8'h69, 8'h96, 8'h69, 8'h96, 6'b110_000, "R12 R10 config pad active again");

        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule